// File: doc/BRIEF.md
# Mask-Driven Element Compress and Expand Unit

This block rearranges the elements of one 128-bit vector under control of a per-element mask. In expand mode it takes the lowest elements of the source vector in order and places them, one by one, into the destination positions whose mask bit is set. In compress mode it does the reverse: it collects the source elements whose mask bit is set and packs them, in order, into the lowest destination positions.

Elements are either 8 or 16 bits wide. A zero-masking flag chooses what happens to destination positions that receive no source element: they are cleared, or they keep the old destination value supplied with the operation. Besides the result vector the unit drives a per-element write-enable, which a store path would use to write only the packed elements of a compress. The position mapping comes from a running count of set mask bits below each position. The result is registered one cycle after a valid strobe.

Top module: `cx_unit`

## Requirements
- R1: `out_valid` is high in the cycle after each cycle with `in_valid` high and low otherwise. `result` and `wr_en` change only on a clock edge where `in_valid` is high.
- R2: Expand (`op_sel`=0): destination element i with mask bit i set receives source element c, where c is the number of set mask bits below position i.
- R3: Expand with `zero_mask`=1: every destination element whose mask bit is clear is zero.
- R4: Expand with `zero_mask`=0: every destination element whose mask bit is clear equals the same element of `old_dst`. For expand, `wr_en` bit i equals mask bit i of the active elements.
- R5: Compress (`op_sel`=1): walking source positions from lowest to highest, each element with a set mask bit goes to the next free destination slot, starting at slot 0.
- R6: Compress: `wr_en` has exactly its lowest k bits set, where k is the number of set mask bits among the active elements.
- R7: Compress: destination elements at index k and above are zero when `zero_mask`=1 and equal `old_dst` when `zero_mask`=0.
- R8: `elem_word`=0 selects 16 byte elements using mask bits 0 to 15. `elem_word`=1 selects 8 word elements using mask bits 0 to 7; mask bits 8 to 15 are ignored and `wr_en` bits 8 to 15 are zero. Element j occupies bits [W*j+W-1 : W*j] for element width W.
- R9: An all-zero mask gives k=0. Compress then sets no `wr_en` bit, and expand with `zero_mask`=1 gives an all-zero `result`.
- R10: While `rst_n` is low, `out_valid`, `result` and `wr_en` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe, one operation per high cycle |
| op_sel | input | 1 | 0 = expand, 1 = compress |
| elem_word | input | 1 | 0 = 8-bit elements, 1 = 16-bit elements |
| zero_mask | input | 1 | 1 = clear unwritten elements, 0 = keep old destination |
| mask | input | 16 | Element mask, bit i controls element i |
| src | input | 128 | Source vector |
| old_dst | input | 128 | Old destination vector used for merging |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| result | output | 128 | Registered result vector |
| wr_en | output | 16 | Registered per-element write-enable |

## Verification
The assertions assume that `op_sel`, `elem_word`, `zero_mask` and `mask` are known (not X) from the first clock edge after reset onward, since each property relates the registered copies of these controls to `wr_en` and `result`. The stimulus drives every control input to a defined value during reset and changes inputs only on the falling clock edge. The source and old-destination patterns use distinct values in every byte, so a wrong slot shows as a wrong value rather than passing by coincidence.

// File: rtl/cx_pkg.sv
package cx_pkg;

  // Upper bound on element count handled by the prefix helper.
  localparam int unsigned CX_MAXN = 64;

  typedef enum logic {
    CX_EXPAND   = 1'b0,
    CX_COMPRESS = 1'b1
  } cx_op_e;

  // Number of set bits in m strictly below position idx.
  function automatic int unsigned cx_ones_below(input logic [CX_MAXN-1:0] m,
                                                input int unsigned idx);
    int unsigned c;
    c = 0;
    for (int unsigned i = 0; i < CX_MAXN; i++) begin
      if (i < idx && m[i]) c++;
    end
    return c;
  endfunction

endpackage

// File: rtl/cx_prefix.sv
module cx_prefix
  import cx_pkg::*;
#(
  parameter int unsigned N  = 16,
  parameter int unsigned CW = $clog2(N + 1)
) (
  input  logic [N-1:0]    mask,
  output logic [N*CW-1:0] pre_flat,
  output logic [CW-1:0]   total
);

  // Exclusive prefix count: slot index each element maps to or from.
  for (genvar i = 0; i < N; i++) begin : g_pre
    assign pre_flat[i*CW +: CW] = CW'(cx_ones_below(CX_MAXN'(mask), i));
  end

  assign total = CW'(cx_ones_below(CX_MAXN'(mask), N));

endmodule

// File: rtl/cx_xbar.sv
module cx_xbar
  import cx_pkg::*;
#(
  parameter int unsigned N  = 16,
  parameter int unsigned EW = 8,
  parameter int unsigned CW = $clog2(N + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    mask,
  input  logic [N*EW-1:0] src_flat,
  input  logic [N*CW-1:0] pre_flat,
  input  logic [CW-1:0]   total,
  output logic [N*EW-1:0] exp_flat,
  output logic [N*EW-1:0] cmp_flat,
  output logic [N-1:0]    exp_keep,
  output logic [N-1:0]    cmp_keep
);

  // Expand: destination i pulls source element numbered by its prefix count.
  for (genvar i = 0; i < N; i++) begin : g_exp
    logic [CW-1:0] sel;
    assign sel                  = pre_flat[i*CW +: CW];
    assign exp_flat[i*EW +: EW] = mask[i] ? src_flat[sel*EW +: EW] : '0;
    assign exp_keep[i]          = mask[i];
  end

  // Compress: slot j collects the one masked source whose prefix equals j.
  for (genvar j = 0; j < N; j++) begin : g_cmp
    logic [N-1:0]  hit;
    logic [EW-1:0] acc;

    for (genvar i = 0; i < N; i++) begin : g_hit
      assign hit[i] = mask[i] && (pre_flat[i*CW +: CW] == CW'(j));
    end

    always_comb begin
      acc = '0;
      for (int i = 0; i < N; i++) begin
        if (hit[i]) acc = acc | src_flat[i*EW +: EW];
      end
    end

    assign cmp_flat[j*EW +: EW] = acc;
    assign cmp_keep[j]          = (CW'(j) < total);

    AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit)); // R5
  end

endmodule

// File: rtl/cx_unit.sv
module cx_unit
  import cx_pkg::*;
#(
  parameter  int unsigned VEC_W = 128,
  localparam int unsigned NB    = VEC_W / 8,
  localparam int unsigned NW    = VEC_W / 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             op_sel,
  input  logic             elem_word,
  input  logic             zero_mask,
  input  logic [NB-1:0]    mask,
  input  logic [VEC_W-1:0] src,
  input  logic [VEC_W-1:0] old_dst,
  output logic             out_valid,
  output logic [VEC_W-1:0] result,
  output logic [NB-1:0]    wr_en
);

  localparam int unsigned NSZ = 2;  // element sizes: 8 and 16 bits

  logic [VEC_W-1:0] sz_exp    [NSZ];
  logic [VEC_W-1:0] sz_cmp    [NSZ];
  logic [NB-1:0]    sz_exp_bk [NSZ];
  logic [NB-1:0]    sz_cmp_bk [NSZ];
  logic [NB-1:0]    sz_exp_ek [NSZ];
  logic [NB-1:0]    sz_cmp_ek [NSZ];

  for (genvar g = 0; g < NSZ; g++) begin : g_sz
    localparam int unsigned EW = 8 << g;
    localparam int unsigned N  = VEC_W / EW;
    localparam int unsigned CW = $clog2(N + 1);
    localparam int unsigned EB = EW / 8;

    logic [N*CW-1:0] pre;
    logic [CW-1:0]   tot;
    logic [N-1:0]    ek;
    logic [N-1:0]    ck;

    cx_prefix #(.N(N), .CW(CW)) u_prefix (
      .mask     (mask[N-1:0]),
      .pre_flat (pre),
      .total    (tot)
    );

    cx_xbar #(.N(N), .EW(EW), .CW(CW)) u_xbar (
      .clk      (clk),
      .rst_n    (rst_n),
      .mask     (mask[N-1:0]),
      .src_flat (src),
      .pre_flat (pre),
      .total    (tot),
      .exp_flat (sz_exp[g]),
      .cmp_flat (sz_cmp[g]),
      .exp_keep (ek),
      .cmp_keep (ck)
    );

    // Widen element-level keep to byte-level keep for the merge stage.
    for (genvar b = 0; b < NB; b++) begin : g_bk
      assign sz_exp_bk[g][b] = ek[b / EB];
      assign sz_cmp_bk[g][b] = ck[b / EB];
    end

    assign sz_exp_ek[g] = NB'(ek);
    assign sz_cmp_ek[g] = NB'(ck);
  end

  // Pick the size variant and the operation.
  logic [VEC_W-1:0] inter;
  logic [NB-1:0]    keep_b;
  logic [NB-1:0]    keep_e;
  logic [VEC_W-1:0] merged;

  always_comb begin
    if (op_sel == CX_COMPRESS) begin
      inter  = sz_cmp[elem_word];
      keep_b = sz_cmp_bk[elem_word];
      keep_e = sz_cmp_ek[elem_word];
    end else begin
      inter  = sz_exp[elem_word];
      keep_b = sz_exp_bk[elem_word];
      keep_e = sz_exp_ek[elem_word];
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_merge
    assign merged[b*8 +: 8] = keep_b[b]  ? inter[b*8 +: 8] :
                              zero_mask  ? 8'h00 : old_dst[b*8 +: 8];
  end

  // Registered outputs plus registered controls named for the assertions.
  logic [NB-1:0] mask_eff;
  logic [NB-1:0] mask_eff_q;
  cx_op_e        op_q;
  logic          word_q;
  logic          zm_q;

  assign mask_eff = elem_word ? NB'(mask[NW-1:0]) : mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      result     <= '0;
      wr_en      <= '0;
      mask_eff_q <= '0;
      op_q       <= CX_EXPAND;
      word_q     <= 1'b0;
      zm_q       <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result     <= merged;
        wr_en      <= keep_e;
        mask_eff_q <= mask_eff;
        op_q       <= cx_op_e'(op_sel);
        word_q     <= elem_word;
        zm_q       <= zero_mask;
      end
    end
  end

  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result) && $stable(wr_en))); // R1
  AST_EXP_WREN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && op_q == CX_EXPAND) |-> (wr_en == mask_eff_q)); // R4
  AST_CMP_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && op_q == CX_COMPRESS) |-> ((wr_en & (wr_en + 1'b1)) == '0)); // R6
  AST_CMP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && op_q == CX_COMPRESS) |-> ($countones(wr_en) == $countones(mask_eff_q))); // R6
  AST_WORD_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && word_q) |-> (wr_en[NB-1:NW] == '0)); // R8
  AST_EXP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && op_q == CX_EXPAND && zm_q && mask_eff_q == '0) |-> (result == '0)); // R9

endmodule

// File: tb/test_cx_unit.sv
`timescale 1ns/1ps
module test_cx_unit;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         op_sel = 1'b0;
  logic         elem_word = 1'b0;
  logic         zero_mask = 1'b0;
  logic [15:0]  mask = '0;
  logic [127:0] src = '0;
  logic [127:0] old_dst = '0;
  logic         out_valid;
  logic [127:0] result;
  logic [15:0]  wr_en;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  cx_unit i_cx_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .elem_word(elem_word), .zero_mask(zero_mask), .mask(mask), .src(src),
    .old_dst(old_dst), .out_valid(out_valid), .result(result), .wr_en(wr_en)
  );

  typedef struct packed {
    logic        op;
    logic        wide;
    logic        zm;
    logic [15:0] m;
  } entry_t;

  localparam int NT = 8;
  localparam entry_t TBL [NT] = '{
    '{1'b0, 1'b0, 1'b0, 16'h8421},
    '{1'b0, 1'b0, 1'b1, 16'hF00F},
    '{1'b1, 1'b0, 1'b0, 16'h0A5A},
    '{1'b1, 1'b0, 1'b1, 16'hC003},
    '{1'b0, 1'b1, 1'b0, 16'h00A5},
    '{1'b0, 1'b1, 1'b1, 16'h0036},
    '{1'b1, 1'b1, 1'b0, 16'h0081},
    '{1'b1, 1'b1, 1'b1, 16'h00FE}
  };

  // Reference: walk positions one at a time with a running counter.
  task automatic model(input logic op, input logic wide, input logic zm,
                       input logic [15:0] m, input logic [127:0] s,
                       input logic [127:0] o,
                       output logic [127:0] r, output logic [15:0] w);
    int n, eb, k;
    n  = wide ? 8 : 16;
    eb = wide ? 2 : 1;
    k  = 0;
    r  = '0;
    w  = '0;
    if (!op) begin
      for (int i = 0; i < n; i++) begin
        if (m[i]) begin
          for (int b = 0; b < eb; b++) r[(i*eb+b)*8 +: 8] = s[(k*eb+b)*8 +: 8];
          k++;
          w[i] = 1'b1;
        end else if (!zm) begin
          for (int b = 0; b < eb; b++) r[(i*eb+b)*8 +: 8] = o[(i*eb+b)*8 +: 8];
        end
      end
    end else begin
      for (int i = 0; i < n; i++) begin
        if (m[i]) begin
          for (int b = 0; b < eb; b++) r[(k*eb+b)*8 +: 8] = s[(i*eb+b)*8 +: 8];
          k++;
        end
      end
      for (int j = 0; j < n; j++) begin
        if (j < k) w[j] = 1'b1;
        else if (!zm)
          for (int b = 0; b < eb; b++) r[(j*eb+b)*8 +: 8] = o[(j*eb+b)*8 +: 8];
      end
    end
  endtask

  task automatic chk(input string tag, input logic [127:0] got, input logic [127:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [127:0] pat(input int seed, input int base);
    logic [127:0] v;
    for (int i = 0; i < 16; i++) v[i*8 +: 8] = 8'(base + i + 16*seed);
    return v;
  endfunction

  // Drive one operation; return after the result edge, at a falling edge.
  task automatic run(input logic op, input logic wide, input logic zm,
                     input logic [15:0] m, input logic [127:0] s, input logic [127:0] o);
    @(negedge clk);
    op_sel = op; elem_word = wide; zero_mask = zm; mask = m; src = s; old_dst = o;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_and_check(input string tag, input logic op, input logic wide,
                               input logic zm, input logic [15:0] m,
                               input logic [127:0] s, input logic [127:0] o);
    logic [127:0] er;
    logic [15:0]  ew;
    model(op, wide, zm, m, s, o, er, ew);
    run(op, wide, zm, m, s, o);
    chk({tag, " out_valid R1"}, 128'(out_valid), 128'(1));
    chk({tag, " result"}, result, er);
    chk({tag, " wr_en"}, 128'(wr_en), 128'(ew));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [127:0] keep_r;
    logic [15:0]  keep_w;

    // R10: reset state
    repeat (3) @(negedge clk);
    chk("R10 out_valid", 128'(out_valid), 128'(0));
    chk("R10 result", result, '0);
    chk("R10 wr_en", 128'(wr_en), 128'(0));
    rst_n = 1'b1;

    // Table: R2 R3 R4 (expand), R5 R6 R7 (compress), R8 (word entries)
    for (int t = 0; t < NT; t++) begin
      string tag;
      if (!TBL[t].op) tag = TBL[t].zm ? "R2/R3 expand zero" : "R2/R4 expand merge";
      else            tag = TBL[t].zm ? "R5/R6/R7 compress zero" : "R5/R6/R7 compress merge";
      if (TBL[t].wide) tag = {tag, " R8 word"};
      run_and_check(tag, TBL[t].op, TBL[t].wide, TBL[t].zm, TBL[t].m,
                    pat(t, 8'hC0), pat(t, 8'h40));
    end

    // R1: idle cycle keeps outputs and drops out_valid
    keep_r = result;
    keep_w = wr_en;
    @(negedge clk);
    op_sel = 1'b0; elem_word = 1'b0; zero_mask = 1'b1; mask = 16'hFFFF;
    src = pat(9, 8'h11);
    @(negedge clk);
    chk("R1 idle out_valid", 128'(out_valid), 128'(0));
    chk("R1 idle result held", result, keep_r);
    chk("R1 idle wr_en held", 128'(wr_en), 128'(keep_w));

    // R9: all-zero mask
    run_and_check("R9 compress empty merge", 1'b1, 1'b0, 1'b0, 16'h0000, pat(3, 8'h90), pat(3, 8'h20));
    run_and_check("R9 expand empty zero", 1'b0, 1'b0, 1'b1, 16'h0000, pat(4, 8'h90), pat(4, 8'h20));
    chk("R9 expand empty is zero", result, '0);

    // R8: word mode ignores mask bits 15..8
    run_and_check("R8 word upper mask ignored", 1'b0, 1'b1, 1'b0, 16'hFF03, pat(5, 8'h70), pat(5, 8'h10));
    chk("R8 word wr_en upper zero", 128'(wr_en[15:8]), 128'(0));
    run_and_check("R8 word compress upper ignored", 1'b1, 1'b1, 1'b1, 16'hAA40, pat(6, 8'h70), pat(6, 8'h10));

    // R6: full byte mask packs all elements
    run_and_check("R6 compress full", 1'b1, 1'b0, 1'b1, 16'hFFFF, pat(7, 8'h05), pat(7, 8'hE0));
    chk("R6 compress full wr_en", 128'(wr_en), 128'(16'hFFFF));

    // R5: single top element lands in slot 0
    run_and_check("R5 compress top only", 1'b1, 1'b0, 1'b0, 16'h8000, pat(2, 8'h33), pat(2, 8'h88));

    // R10: reset in mid-run clears outputs
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10 reset again result", result, '0);
    chk("R10 reset again wr_en", 128'(wr_en), 128'(0));

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule